// File: doc/BRIEF.md
# Half-Bridge Recovery and Clamp Control Decoder

This block sits between the timing logic of a capacitive-load driver and its half-bridge output stage. The output stage has two resonant energy-recovery paths: one swings the load from low to high and one swings it from high to low. It also has two hard clamps, one that ties the load to the high-voltage supply and one that ties it to ground. Each cycle the block takes four active-high requests, one per path, and turns them into at most one registered switch enable.

Any overlapping request combination would short a supply or fight a recovery path, so the block forces the stage into a safe tri-state for it. It does the same when no path is requested, when either supply is not yet valid, and when the die reports over-temperature. A registered protection flag tells the controller that the current tri-state was forced. A sticky fault bit remembers that an illegal request combination was seen, until a synchronous clear.

When the stage leaves a driven mode for any other mode, one tri-state cycle is inserted as dead time, so the two switches of the bridge never conduct in adjacent cycles.

Top module: `hb_drive_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mode_o` is 0 (tri-state), `en_o` is 0, `prot_o` is 0 and `fault_o` is 0.
- R2: The request code {rise,fall,lclamp,hclamp} = 1000 selects the low-to-high recovery mode (`mode_o` = 1).
- R3: The code 0100 selects the high-to-low recovery mode (`mode_o` = 2).
- R4: `hclamp` = 1 with `fall` = 0 and `lclamp` = 0 selects the supply clamp (`mode_o` = 3), whatever the value of `rise`.
- R5: `lclamp` = 1 with `rise` = 0 and `hclamp` = 0 selects the ground clamp (`mode_o` = 4), whatever the value of `fall`.
- R6: Each of these combinations is illegal and forces tri-state with `prot_o` = 1: both clamps high, rise and lclamp both high, fall and hclamp both high, or rise and fall both high with both clamps low.
- R7: The all-zero code gives tri-state with `prot_o` = 0, and it does not set the sticky fault.
- R8: Unless `logic_ok` and `hv_ok` are both 1, the output is tri-state with `prot_o` = 1. This holds whichever of the two supplies comes up first.
- R9: While `overtemp` is 1, the output is tri-state with `prot_o` = 1.
- R10: The encoding of `en_o` is bit 0 = rise, bit 1 = fall, bit 2 = supply clamp, bit 3 = ground clamp. At most one bit is set, and it matches `mode_o`.
- R11: A transition from a driven mode to any different mode passes through exactly one tri-state cycle. A request that holds the same mode causes no gap.
- R12: `fault_o` sets on any illegal code and stays set until `fault_clr` is 1. If a clear and an illegal code arrive in the same cycle, the bit stays set.
- R13: Outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rise | input | 1 | Low-to-high recovery request |
| req_fall | input | 1 | High-to-low recovery request |
| req_lclamp | input | 1 | Ground clamp request |
| req_hclamp | input | 1 | Supply clamp request |
| logic_ok | input | 1 | Logic supply above threshold |
| hv_ok | input | 1 | High-voltage supply above threshold |
| overtemp | input | 1 | Die over-temperature flag |
| fault_clr | input | 1 | Synchronous clear of the sticky fault |
| en_o | output | 4 | One-hot switch enables |
| mode_o | output | 3 | Current mode code |
| prot_o | output | 1 | Current tri-state was forced by protection |
| fault_o | output | 1 | Sticky illegal-code fault |

## Verification
A corrupted mode register shows on the very next cycle. Either `en_o` and `mode_o` disagree, or a driven mode is followed directly by a different driven mode with no tri-state gap, and the scoreboard compares both on every cycle. A dead-time counter that is stuck nonzero holds the stage in tri-state, and this is seen one cycle after any legal request. A sticky bit that misses a set or a clear is caught in the cycle after the illegal-code sweep or the clear pulse. Every one of the sixteen request codes is applied with idle cycles between, so a wrong decode entry shows up as a wrong mode one cycle after that code.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int N_SW = 4;
    localparam int MODE_W = 3;

    localparam int EN_RISE   = 0;
    localparam int EN_FALL   = 1;
    localparam int EN_HCLAMP = 2;
    localparam int EN_LCLAMP = 3;

    typedef enum logic [MODE_W-1:0] {
        HB_HIZ    = 3'd0,
        HB_RISE   = 3'd1,
        HB_FALL   = 3'd2,
        HB_HCLAMP = 3'd3,
        HB_LCLAMP = 3'd4
    } hb_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic lclamp;
        logic hclamp;
    } hb_req_t;

    function automatic logic [N_SW-1:0] mode_to_en(hb_mode_e m);
        logic [N_SW-1:0] e;
        e = '0;
        case (m)
            HB_RISE:   e[EN_RISE]   = 1'b1;
            HB_FALL:   e[EN_FALL]   = 1'b1;
            HB_HCLAMP: e[EN_HCLAMP] = 1'b1;
            HB_LCLAMP: e[EN_LCLAMP] = 1'b1;
            default:   e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/hbd_code_decoder.sv
module hbd_code_decoder
    import hbd_pkg::*;
(
    input  hb_req_t  req,
    output hb_mode_e tgt,
    output logic     illegal
);
    logic overlap;

    always_comb begin
        overlap = (req.hclamp & req.lclamp)
                | (req.rise & req.lclamp)
                | (req.fall & req.hclamp);
        illegal = overlap | (req.rise & req.fall & ~req.lclamp & ~req.hclamp);

        tgt = HB_HIZ;
        if (!illegal) begin
            if (req.hclamp)
                tgt = HB_HCLAMP;
            else if (req.lclamp)
                tgt = HB_LCLAMP;
            else if (req.rise)
                tgt = HB_RISE;
            else if (req.fall)
                tgt = HB_FALL;
        end
    end
endmodule

// File: rtl/hbd_guard.sv
module hbd_guard
    import hbd_pkg::*;
(
    input  hb_mode_e tgt_in,
    input  logic     illegal,
    input  logic     logic_ok,
    input  logic     hv_ok,
    input  logic     overtemp,
    output hb_mode_e tgt_out,
    output logic     prot
);
    always_comb begin
        prot    = illegal | ~(logic_ok & hv_ok) | overtemp;
        tgt_out = prot ? HB_HIZ : tgt_in;
    end
endmodule

// File: rtl/hbd_sequencer.sv
module hbd_sequencer
    import hbd_pkg::*;
#(
    parameter int DEAD_CYCLES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  hb_mode_e        tgt,
    input  logic            prot_in,
    output hb_mode_e        mode_q,
    output logic [N_SW-1:0] en_q,
    output logic            prot_q
);
    localparam int CW = $clog2(DEAD_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYCLES - 1);

    logic [CW-1:0] dead_cnt, dead_nxt;
    hb_mode_e      mode_nxt;

    always_comb begin
        if (dead_cnt != '0) begin
            mode_nxt = HB_HIZ;
            dead_nxt = dead_cnt - 1'b1;
        end else if (mode_q != HB_HIZ && tgt != mode_q) begin
            mode_nxt = HB_HIZ;
            dead_nxt = RELOAD;
        end else begin
            mode_nxt = tgt;
            dead_nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= HB_HIZ;
            en_q     <= '0;
            prot_q   <= 1'b0;
            dead_cnt <= '0;
        end else begin
            mode_q   <= mode_nxt;
            en_q     <= mode_to_en(mode_nxt);
            prot_q   <= prot_in;
            dead_cnt <= dead_nxt;
        end
    end
endmodule

// File: rtl/hbd_fault_latch.sv
module hbd_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= set_i | (flag_q & ~clr_i);
    end
endmodule

// File: rtl/hb_drive_decoder.sv
module hb_drive_decoder
    import hbd_pkg::*;
#(
    parameter int DEAD_CYCLES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_rise,
    input  logic            req_fall,
    input  logic            req_lclamp,
    input  logic            req_hclamp,
    input  logic            logic_ok,
    input  logic            hv_ok,
    input  logic            overtemp,
    input  logic            fault_clr,
    output logic [N_SW-1:0] en_o,
    output logic [MODE_W-1:0] mode_o,
    output logic            prot_o,
    output logic            fault_o
);
    hb_req_t  req;
    hb_mode_e raw_tgt, safe_tgt, mode_q;
    logic     illegal, prot;

    assign req = '{rise: req_rise, fall: req_fall, lclamp: req_lclamp, hclamp: req_hclamp};

    hbd_code_decoder u_dec (
        .req     (req),
        .tgt     (raw_tgt),
        .illegal (illegal)
    );

    hbd_guard u_guard (
        .tgt_in   (raw_tgt),
        .illegal  (illegal),
        .logic_ok (logic_ok),
        .hv_ok    (hv_ok),
        .overtemp (overtemp),
        .tgt_out  (safe_tgt),
        .prot     (prot)
    );

    hbd_sequencer #(.DEAD_CYCLES(DEAD_CYCLES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tgt     (safe_tgt),
        .prot_in (prot),
        .mode_q  (mode_q),
        .en_q    (en_o),
        .prot_q  (prot_o)
    );

    hbd_fault_latch u_fault (
        .clk    (clk),
        .rst    (rst),
        .set_i  (illegal),
        .clr_i  (fault_clr),
        .flag_q (fault_o)
    );

    assign mode_o = mode_q;
endmodule

// File: rtl/hb_drive_decoder_chk.sv
module hb_drive_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_rise,
    input logic       req_fall,
    input logic       req_lclamp,
    input logic       req_hclamp,
    input logic       logic_ok,
    input logic       hv_ok,
    input logic       overtemp,
    input logic       fault_clr,
    input logic [3:0] en_o,
    input logic [2:0] mode_o,
    input logic       prot_o,
    input logic       fault_o
);
    logic bad_code;
    assign bad_code = (req_hclamp && req_lclamp) || (req_rise && req_lclamp)
                   || (req_fall && req_hclamp)
                   || (req_rise && req_fall && !req_lclamp && !req_hclamp);

    // R10
    p_onehot_r10: assert property (@(posedge clk) disable iff (rst) $onehot0(en_o));

    // R10
    p_en_mode_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd0) == (en_o == 4'd0));

    // R11
    p_dead_gap_r11: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 3'd0) |=> (mode_o == 3'd0 || $stable(mode_o)));

    // R9
    p_hot_off_r9: assert property (@(posedge clk) disable iff (rst)
        overtemp |=> (en_o == 4'd0 && prot_o));

    // R8
    p_supply_off_r8: assert property (@(posedge clk) disable iff (rst)
        !(logic_ok && hv_ok) |=> (en_o == 4'd0 && prot_o));

    // R6
    p_bad_code_r6: assert property (@(posedge clk) disable iff (rst)
        bad_code |=> (en_o == 4'd0 && prot_o && fault_o));

    // R12
    p_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (fault_clr && !bad_code) |=> !fault_o);

    // R12
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (fault_o && !fault_clr) |=> fault_o);
endmodule

bind hb_drive_decoder hb_drive_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_rise   (req_rise),
    .req_fall   (req_fall),
    .req_lclamp (req_lclamp),
    .req_hclamp (req_hclamp),
    .logic_ok   (logic_ok),
    .hv_ok      (hv_ok),
    .overtemp   (overtemp),
    .fault_clr  (fault_clr),
    .en_o       (en_o),
    .mode_o     (mode_o),
    .prot_o     (prot_o),
    .fault_o    (fault_o)
);

// File: tb/hb_drive_decoder_test.sv
`timescale 1ns/1ps
module hb_drive_decoder_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic r = 0, f = 0, lc = 0, hc = 0, lok = 0, hok = 0, ot = 0, clr = 0;
    logic [3:0] en_o;
    logic [2:0] mode_o;
    logic prot_o, fault_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [8:0] q_exp[$];
    string      q_tag[$];

    logic [2:0] m_mode = 3'd0;
    logic       m_sticky = 1'b0;

    always #5 clk = ~clk;

    hb_drive_decoder uut (
        .clk(clk), .rst(rst), .req_rise(r), .req_fall(f), .req_lclamp(lc),
        .req_hclamp(hc), .logic_ok(lok), .hv_ok(hok), .overtemp(ot),
        .fault_clr(clr), .en_o(en_o), .mode_o(mode_o), .prot_o(prot_o),
        .fault_o(fault_o)
    );

    function automatic logic [3:0] en_of(logic [2:0] m);
        case (m)
            3'd1: return 4'b0001;
            3'd2: return 4'b0010;
            3'd3: return 4'b0100;
            3'd4: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    // Returns {illegal, mode}
    function automatic logic [3:0] ref_decode(logic [3:0] c);
        case (c)   // {rise, fall, lclamp, hclamp}
            4'b0000: return {1'b0, 3'd0};
            4'b1000: return {1'b0, 3'd1};
            4'b0100: return {1'b0, 3'd2};
            4'b0001: return {1'b0, 3'd3};
            4'b1001: return {1'b0, 3'd3};
            4'b0010: return {1'b0, 3'd4};
            4'b0110: return {1'b0, 3'd4};
            default: return {1'b1, 3'd0};
        endcase
    endfunction

    task automatic step(input logic ir, input logic ifl, input logic il, input logic ih,
                        input logic ilok, input logic ihok, input logic iot,
                        input logic iclr, input string tag);
        logic [3:0] d;
        logic [2:0] tgt, nxt;
        logic prot;
        @(negedge clk);
        r = ir; f = ifl; lc = il; hc = ih; lok = ilok; hok = ihok; ot = iot; clr = iclr;
        d = ref_decode({ir, ifl, il, ih});
        prot = d[3] | ~(ilok & ihok) | iot;
        tgt = prot ? 3'd0 : d[2:0];
        nxt = (m_mode != 3'd0 && tgt != m_mode) ? 3'd0 : tgt;
        m_sticky = d[3] | (m_sticky & ~iclr);
        m_mode = nxt;
        q_exp.push_back({nxt, en_of(nxt), prot, m_sticky});
        q_tag.push_back(tag);
    endtask

    // Monitor: compare one expected item per clock after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [8:0] e;
                logic [8:0] a;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = {mode_o, en_o, prot_o, fault_o};
                n_chk++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: {mode,en,prot,fault} actual=%b expected=%b", t, a, e);
                end
                n_chk++;
                if ($countones(en_o) > 1) begin
                    n_bad++;
                    $display("FAIL R10: en actual=%b expected at most one bit", en_o);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if ({mode_o, en_o, prot_o, fault_o} !== 9'd0) begin
            n_bad++;
            $display("FAIL R1: actual=%b expected=%b", {mode_o, en_o, prot_o, fault_o}, 9'd0);
        end
        rst = 1'b0;

        // R8: supplies in either order
        step(1,0,0,0, 0,0,0,0, "R8 none");
        step(1,0,0,0, 1,0,0,0, "R8 logic only");
        step(1,0,0,0, 0,1,0,0, "R8 hv only");
        step(0,0,0,0, 1,1,0,0, "R7 idle");
        step(1,0,0,0, 1,1,0,0, "R2 R13 rise");
        step(1,0,0,0, 1,1,0,0, "R11 hold rise");
        step(0,1,0,0, 1,1,0,0, "R11 dead to fall");
        step(0,1,0,0, 1,1,0,0, "R3 fall");
        step(1,0,0,1, 1,1,0,0, "R11 dead to hclamp");
        step(1,0,0,1, 1,1,0,0, "R4 hclamp rise dc");
        step(0,0,0,1, 1,1,0,0, "R4 hclamp");
        step(0,0,0,1, 1,1,1,0, "R9 overtemp");
        step(0,1,1,0, 1,1,1,0, "R9 overtemp hold");
        step(0,1,1,0, 1,1,0,0, "R5 lclamp fall dc");
        step(0,0,1,0, 1,1,0,0, "R5 lclamp");
        step(0,0,1,0, 1,0,0,0, "R8 hv drop");
        step(0,0,0,0, 1,1,0,0, "R7 idle no fault");
        step(1,1,0,0, 1,1,0,0, "R6 R12 both recovery");
        step(0,0,0,0, 1,1,0,0, "R12 sticky held");
        step(0,0,0,0, 1,1,0,1, "R12 clear");
        step(0,0,0,0, 1,1,0,0, "R12 cleared");

        for (int c = 0; c < 16; c++) begin
            step(c[3], c[2], c[1], c[0], 1,1,0,0, "R6 sweep");
            step(0,0,0,0, 1,1,0,0, "R11 sweep idle");
        end

        step(1,0,1,0, 1,1,0,1, "R12 set wins over clear");
        step(0,0,0,0, 1,1,0,1, "R12 clear after");
        step(0,0,0,1, 1,1,0,0, "R4 from idle");
        step(1,0,0,0, 1,1,0,0, "R11 dead hclamp to rise");
        step(1,0,0,0, 1,1,0,0, "R2 rise after gap");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule